// File: doc/BRIEF.md
# Calendar Alarm Field Comparator

This unit sits next to a BCD calendar counter and watches six of its fields: seconds, minutes, hours, day of week, day of month and month. Software programs one alarm byte per field. The top bit of each byte switches comparison for that field on or off, and the lower seven bits hold the BCD target. Fields that are switched off act as wildcards. This lets one alarm express "every hour at :30:00" as easily as a full date and time.

The counter block raises a one-cycle strobe each second once its fields have settled. On that strobe the unit checks every armed field against the live value. When all armed fields agree, it latches a sticky alarm flag. An interrupt line follows the flag, gated by a software enable. The flag and the enable share one control byte on a small byte-wide register port. The read data path is combinational.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset all six alarm bytes read 0x00, the control byte reads 0x00 and `irq_o` is low.
- R2: The register port decodes `reg_addr_i` as follows: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 control, 7 unused. A write to addresses 0 to 5 stores all 8 bits, and a read returns them. Address 7 reads 0x00 and ignores writes. A control read returns the alarm flag in bit 0, the interrupt enable in bit 3, and zeros in the other bits.
- R3: On the clock edge where `sec_tick_i` is high, the flag is set when every armed field (alarm byte bit 7 = 1) has bits 6:0 equal to the 7-bit current value of that field. The flag is visible on the cycle after the strobe.
- R4: A field whose alarm byte has bit 7 = 0 does not affect the match, whatever its stored value or its current value. Writing 0x00 to a byte therefore disarms that field.
- R5: When all six bytes have bit 7 = 0, the flag is never set.
- R6: Without `sec_tick_i`, a matching time never sets the flag.
- R7: Once set, the flag stays set through later mismatches. Only a control write with bit 0 = 0 clears it. A control write with bit 0 = 1 leaves the flag unchanged and cannot set it.
- R8: `irq_o` is high exactly while both the flag and the interrupt enable (control bit 3, written from `reg_wdata_i[3]`) are 1.
- R9: When a flag-clearing control write and a match strobe fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick_i | input | 1 | One-cycle strobe, once per second, with settled counters |
| cur_sec_i | input | 7 | Current seconds, BCD |
| cur_min_i | input | 7 | Current minutes, BCD |
| cur_hour_i | input | 7 | Current hours, BCD |
| cur_wday_i | input | 7 | Current day of week, BCD |
| cur_mday_i | input | 7 | Current day of month, BCD |
| cur_month_i | input | 7 | Current month, BCD 1 to 12 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench walks through all 64 arming patterns. For each pattern it strobes once with every field matching, and then once more for each field with only that field disturbed. A design that treats disarmed fields as compared would miss partial alarms. One that ignores an armed field would fire on a wrong time. One that counts an all-disarmed alarm as a match would fire every second. The bench also checks the cases where the flag is written 1, where it is cleared in the same cycle as a match, and where it is not strobed. A wrong priority, a flag that can be set from software, or a compare that is not gated by the strobe each shows up as a flag value different from the one computed in the bench.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned FIELD_CNT = 6;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned VAL_W     = BYTE_W - 1;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned ARM_BIT   = BYTE_W - 1;
  localparam int unsigned FLAG_BIT  = 0;
  localparam int unsigned IE_BIT    = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_WDAY  = 3'd3,
    SEL_MDAY  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_CTRL  = 3'd6,
    SEL_SPARE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int unsigned BW = 8
) (
  input  logic [BW-1:0] alarm_byte_i,
  input  logic [BW-2:0] cur_val_i,
  output logic          armed_o,
  output logic          hit_o
);
  logic same;

  always_comb begin
    armed_o = alarm_byte_i[BW-1];
    same    = (alarm_byte_i[BW-2:0] == cur_val_i);
    hit_o   = !armed_o || same;
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int unsigned NF = FIELD_CNT,
  parameter int unsigned BW = BYTE_W
) (
  input  logic [NF-1:0][BW-1:0] alarm_q_i,
  input  logic [NF-1:0][BW-2:0] cur_i,
  output logic                  match_o
);
  logic [NF-1:0] armed_vec;
  logic [NF-1:0] hit_vec;

  for (genvar f = 0; f < NF; f++) begin : g_field
    alarm_field_cmp #(.BW(BW)) i_cmp (
      .alarm_byte_i (alarm_q_i[f]),
      .cur_val_i    (cur_i[f]),
      .armed_o      (armed_vec[f]),
      .hit_o        (hit_vec[f])
    );
  end

  always_comb begin
    match_o = (|armed_vec) && (&hit_vec);
  end
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int unsigned NF = FIELD_CNT,
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [BW-1:0]         wdata_i,
  input  logic                  flag_i,
  output logic [NF-1:0][BW-1:0] alarm_q_o,
  output logic                  ie_o,
  output logic                  clr_req_o,
  output logic [BW-1:0]         rdata_o
);
  logic [NF-1:0][BW-1:0] alarm_d, alarm_q;
  logic                  ie_d, ie_q;
  logic                  ctrl_hit;

  always_comb begin
    alarm_d  = alarm_q;
    ie_d     = ie_q;
    ctrl_hit = wr_i && (addr_i == SEL_CTRL);
    if (wr_i && (int'(addr_i) < NF)) begin
      alarm_d[addr_i] = wdata_i;
    end
    if (ctrl_hit) begin
      ie_d = wdata_i[IE_BIT];
    end
    clr_req_o = ctrl_hit && !wdata_i[FLAG_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      ie_q    <= 1'b0;
    end else begin
      alarm_q <= alarm_d;
      ie_q    <= ie_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) < NF) begin
      rdata_o = alarm_q[addr_i];
    end else if (addr_i == SEL_CTRL) begin
      rdata_o[FLAG_BIT] = flag_i;
      rdata_o[IE_BIT]   = ie_q;
    end
  end

  assign alarm_q_o = alarm_q;
  assign ie_o      = ie_q;

  // R2: a write to an alarm byte is stored whole
  p_byte_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (int'(addr_i) < NF)) |=> (alarm_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic match_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_d, flag_q, set_ev;

  always_comb begin
    set_ev = tick_i && match_i;
    flag_d = flag_q;
    if (set_ev) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_i;

  // R6: the flag only rises after a strobed match
  p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick_i && match_i));
  // R7: the flag only falls after a clear request
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_i));
  // R9: setting beats clearing
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && match_i && clr_i) |=> flag_q);
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick_i,
  input  logic [VAL_W-1:0]  cur_sec_i,
  input  logic [VAL_W-1:0]  cur_min_i,
  input  logic [VAL_W-1:0]  cur_hour_i,
  input  logic [VAL_W-1:0]  cur_wday_i,
  input  logic [VAL_W-1:0]  cur_mday_i,
  input  logic [VAL_W-1:0]  cur_month_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [FIELD_CNT-1:0][BYTE_W-1:0] alarm_q;
  logic [FIELD_CNT-1:0][VAL_W-1:0]  cur_vec;
  logic [FIELD_CNT-1:0]             armed_bits;
  logic ie, clr_req, match, flag;

  always_comb begin
    cur_vec[SEL_SEC]   = cur_sec_i;
    cur_vec[SEL_MIN]   = cur_min_i;
    cur_vec[SEL_HOUR]  = cur_hour_i;
    cur_vec[SEL_WDAY]  = cur_wday_i;
    cur_vec[SEL_MDAY]  = cur_mday_i;
    cur_vec[SEL_MONTH] = cur_month_i;
  end

  for (genvar f = 0; f < FIELD_CNT; f++) begin : g_arm
    assign armed_bits[f] = alarm_q[f][ARM_BIT];
  end

  alarm_regs #(.NF(FIELD_CNT), .BW(BYTE_W), .AW(ADDR_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .flag_i    (flag),
    .alarm_q_o (alarm_q),
    .ie_o      (ie),
    .clr_req_o (clr_req),
    .rdata_o   (reg_rdata_o)
  );

  alarm_match #(.NF(FIELD_CNT), .BW(BYTE_W)) i_match (
    .alarm_q_i (alarm_q),
    .cur_i     (cur_vec),
    .match_o   (match)
  );

  alarm_flag i_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (sec_tick_i),
    .match_i (match),
    .clr_i   (clr_req),
    .ie_i    (ie),
    .flag_o  (flag),
    .irq_o   (irq_o)
  );

  // R5: nothing armed means no match
  p_none_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_bits == '0) |-> !match);
  // R8: the interrupt needs the enable
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ie);
endmodule

// File: tb/test_cal_alarm_unit.sv
module test_cal_alarm_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] cur [6];
  logic       wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  int n_checks = 0;
  int n_fail = 0;
  logic [6:0] tgt [6] = '{7'h45, 7'h30, 7'h23, 7'h06, 7'h31, 7'h12};

  always #4 clk = ~clk;

  cal_alarm_unit i_cal_alarm_unit (
    .clk(clk), .rst_n(rst_n), .sec_tick_i(tick),
    .cur_sec_i(cur[0]), .cur_min_i(cur[1]), .cur_hour_i(cur[2]),
    .cur_wday_i(cur[3]), .cur_mday_i(cur[4]), .cur_month_i(cur[5]),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_cur_to_tgt();
    for (int f = 0; f < 6; f++) cur[f] = tgt[f];
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    for (int f = 0; f < 6; f++) cur[f] = 7'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd_reg(a[2:0], r);
      check("R1", r, 8'h00);
    end
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R2 readback
    for (int a = 0; a < 6; a++) wr_reg(a[2:0], 8'h11 * (a + 1) + 8'h80);
    for (int a = 0; a < 6; a++) begin
      rd_reg(a[2:0], r);
      check("R2", r, 8'h11 * (a + 1) + 8'h80);
    end
    wr_reg(3'd7, 8'hA5);
    rd_reg(3'd7, r);
    check("R2 spare", r, 8'h00);
    wr_reg(3'd6, 8'hFF);
    rd_reg(3'd6, r);
    check("R7 write-one no set", r, 8'h08);
    wr_reg(3'd6, 8'h00);

    // R3 R4 R5 sweep of all arming patterns
    for (int m = 0; m < 64; m++) begin
      for (int p = -1; p < 6; p++) begin
        logic expf;
        wr_reg(3'd6, 8'h00);
        for (int f = 0; f < 6; f++)
          wr_reg(f[2:0], m[f] ? {1'b1, tgt[f]} : ((f % 2 == 0) ? 8'h00 : {1'b0, tgt[f]}));
        set_cur_to_tgt();
        if (p >= 0) cur[p] = tgt[p] ^ 7'h01;
        expf = (m != 0) && !(p >= 0 && m[p]);
        pulse_tick();
        rd_reg(3'd6, r);
        if (m == 0) check("R5", r, 8'h00);
        else if (p >= 0 && !m[p]) check("R4", r, {7'b0, expf});
        else check("R3", r, {7'b0, expf});
      end
    end

    // R6 no tick
    wr_reg(3'd6, 8'h00);
    for (int f = 0; f < 6; f++) wr_reg(f[2:0], {1'b1, tgt[f]});
    set_cur_to_tgt();
    repeat (5) @(negedge clk);
    rd_reg(3'd6, r);
    check("R6", r, 8'h00);

    // R7 sticky
    pulse_tick();
    cur[0] = 7'h00;
    pulse_tick();
    rd_reg(3'd6, r);
    check("R7 hold", r, 8'h01);
    wr_reg(3'd6, 8'h01);
    rd_reg(3'd6, r);
    check("R7 write-one keep", r, 8'h01);
    // R8 interrupt gating
    check("R8 ie0", {7'b0, irq}, 8'h00);
    wr_reg(3'd6, 8'h09);
    #1 check("R8 both", {7'b0, irq}, 8'h01);
    wr_reg(3'd6, 8'h08);
    rd_reg(3'd6, r);
    check("R7 clear", r, 8'h08);
    check("R8 flag0", {7'b0, irq}, 8'h00);

    // R9 clear and set in the same cycle
    set_cur_to_tgt();
    pulse_tick();
    @(negedge clk); wr = 1'b1; addr = 3'd6; wdata = 8'h08; tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    rd_reg(3'd6, r);
    check("R9", r, 8'h09);
    check("R9 irq", {7'b0, irq}, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule